// File: doc/BRIEF.md
# Serial Command Frame Port

This block is the serial front end of a dual-channel setting controller. A host drives an active-low select, a serial clock and a data line. While the select is low, the block shifts in 24-bit frames most significant bit first. Each frame holds a command/address byte followed by two data bytes. The command code is the upper nibble of the first byte and the address is its lower nibble. Address 0 picks the first channel and address 1 the second. The register logic behind the port sees a decoded command only when the select returns high, and only if exactly 24 serial clocks were counted in that frame.

All serial inputs are brought into the system clock domain through a synchronizer and edge detector. The serial output passes on the previous 24 bits shifted in, so several ports can be chained on one bus. After either readback command, the two data bytes held in the shift register are overwritten with a value returned by the register logic. The next full frame then carries that value out. The output models an open-drain pin: an enable that pulls the line low for a 0 bit and releases it for a 1 bit.

Top module: `serial_cmd_port`

## Requirements
- R1: On a strobe, `cmd_code` equals frame bits 23..20, `cmd_addr` equals bits 19..16 and `cmd_data` equals bits 15..0, where bit 23 is the first bit sampled on a rising serial clock.
- R2: `cmd_valid` is a single-cycle pulse that follows the rising edge of `cs_n` after a frame of exactly 24 rising serial clocks. It is never raised while the frame is still shifting.
- R3: A frame of any other length (0, 23 or 25 rising serial clocks) produces no strobe.
- R4: During a frame, the serial output presents, most significant bit first, the 24 bits that were last shifted in. The output advances one bit per rising serial clock, including bits left over from frames of the wrong length.
- R5: After a strobe carrying command code 9 or 10, bits 15..0 of the shift register are replaced by `rb_data`. The next frame therefore shifts out the received command/address byte followed by that value.
- R6: Any command code other than 9 or 10 leaves the shift register untouched, so the next frame shifts out the received frame unchanged.
- R7: `sdo_oe` is high only while the port is selected and the bit being presented is 0. It is low whenever `cs_n` is high.
- R8: After reset, `cmd_valid` is 0, all decoded fields are 0, `sdo_oe` is 0, and the first selected frame shifts out 24 zero bits.
- R9: `cmd_code`, `cmd_addr` and `cmd_data` hold their values between strobes, including across discarded frames.
- R10: `rb_data` is taken only in the cycle where `cmd_valid` is high. Later changes to it do not alter the value that is shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| cs_n | input | 1 | Active-low select; frame ends on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| sdo_oe | output | 1 | Open-drain pull-down enable (1 drives the line low) |
| cmd_valid | output | 1 | One-cycle strobe for a complete frame |
| cmd_code | output | 4 | Decoded command code |
| cmd_addr | output | 4 | Decoded address (0 first channel, 1 second) |
| cmd_data | output | 16 | Decoded data bytes |
| rb_data | input | 16 | Readback value, valid while `cmd_valid` is high |

## Verification
The bench builds the port with its default two-stage synchronizer and the fixed 24-bit frame. It uses a serial half period of six system clocks, so every synchronizer and edge-detect delay settles between serial edges. Because the command field is only four bits wide, the bench sweeps every command code against both channel addresses. It keeps a bit-level model of the shift register, which lets it predict each output bit through readback substitution, plain daisy-chain passing and frames that are too short or too long.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int FRAME_W = 24;
    localparam int CODE_W  = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = FRAME_W - CODE_W - ADDR_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        code_t code;
        addr_t addr;
        data_t data;
    } frame_t;

    localparam code_t CODE_RB_STORED = code_t'(9);
    localparam code_t CODE_RB_LIVE   = code_t'(10);

    function automatic logic is_readback(input code_t c);
        return (c == CODE_RB_STORED) || (c == CODE_RB_LIVE);
    endfunction

    function automatic frame_t split_frame(input logic [FRAME_W-1:0] w);
        return frame_t'(w);
    endfunction

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_pipe
            logic [STAGES-1:0][W-1:0] pipe;

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end

            assign q = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sercmd_edge.sv
module sercmd_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic csn_s,
    output logic sclk_rise,
    output logic cs_rise,
    output logic cs_fall,
    output logic cs_act
);

    logic sclk_q;
    logic csn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign cs_rise   = csn_s & ~csn_q;
    assign cs_fall   = ~csn_s & csn_q;
    assign cs_act    = ~csn_s;

endmodule

// File: rtl/sercmd_shift.sv
module sercmd_shift #(
    parameter int FRAME_W = 24,
    parameter int LOAD_W  = 16,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               sdi,
    input  logic               clear_cnt,
    input  logic               load_en,
    input  logic [LOAD_W-1:0]  load_val,
    output logic [FRAME_W-1:0] shreg,
    output logic [CNT_W-1:0]   bit_cnt
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load_en) begin
            shreg[LOAD_W-1:0] <= load_val;
        end else if (shift_en) begin
            shreg <= {shreg[FRAME_W-2:0], sdi};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
        end else if (clear_cnt) begin
            bit_cnt <= '0;
        end else if (shift_en && bit_cnt != CNT_SAT) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sercmd_framer.sv
module sercmd_framer
    import sercmd_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_rise,
    input  logic [CNT_W-1:0]   bit_cnt,
    input  logic [FRAME_W-1:0] shreg,
    output logic               valid,
    output frame_t             fields
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic complete;
    assign complete = cs_rise && (bit_cnt == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            fields <= '0;
        end else begin
            valid <= complete;
            if (complete) fields <= split_frame(shreg);
        end
    end

endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
    import sercmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo_oe,
    output logic              cmd_valid,
    output logic [CODE_W-1:0] cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    input  logic [DATA_W-1:0] rb_data
);

    localparam int CNT_W = $clog2(FRAME_W + 2);

    logic sclk_s, csn_s, sdi_s;
    logic sclk_rise, cs_rise, cs_fall, cs_act;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic               load_en;
    frame_t             fields;

    sercmd_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, cs_n, sdi}),
        .q   ({sclk_s, csn_s, sdi_s})
    );

    sercmd_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (sclk_s),
        .csn_s     (csn_s),
        .sclk_rise (sclk_rise),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .cs_act    (cs_act)
    );

    sercmd_shift #(
        .FRAME_W (FRAME_W),
        .LOAD_W  (DATA_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (sclk_rise & cs_act),
        .sdi       (sdi_s),
        .clear_cnt (cs_fall),
        .load_en   (load_en),
        .load_val  (rb_data),
        .shreg     (shreg),
        .bit_cnt   (bit_cnt)
    );

    sercmd_framer #(
        .CNT_W (CNT_W)
    ) u_framer (
        .clk     (clk),
        .rst     (rst),
        .cs_rise (cs_rise),
        .bit_cnt (bit_cnt),
        .shreg   (shreg),
        .valid   (cmd_valid),
        .fields  (fields)
    );

    assign load_en  = cmd_valid && is_readback(fields.code);
    assign cmd_code = fields.code;
    assign cmd_addr = fields.addr;
    assign cmd_data = fields.data;
    assign sdo_oe   = cs_act & ~shreg[FRAME_W-1];

endmodule

// File: rtl/sercmd_checker.sv
module sercmd_checker
    import sercmd_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [CODE_W-1:0] cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic              cs_rise,
    input logic              cs_fall,
    input logic              cs_act,
    input logic              sdo_oe,
    input logic [CNT_W-1:0]  bit_cnt
);

    // R2: strobe lasts one cycle
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R2: strobe only follows a select release
    p_strobe_after_release_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(cs_rise));

    // R3: strobe only after exactly one frame length of clocks
    p_strobe_len_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(bit_cnt) == CNT_W'(FRAME_W)));

    // R3: counter restarts at each select fall
    p_count_clear_r3: assert property (@(posedge clk) disable iff (rst)
        $past(cs_fall) |-> (bit_cnt == '0));

    // R9: decoded fields change only with a strobe
    p_fields_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> $stable({cmd_code, cmd_addr, cmd_data}));

    // R7: line released while deselected
    p_release_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !cs_act |-> !sdo_oe);

endmodule

bind serial_cmd_port sercmd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .cs_act    (cs_act),
    .sdo_oe    (sdo_oe),
    .bit_cnt   (bit_cnt)
);

// File: tb/tb_serial_cmd_port.sv
module tb_serial_cmd_port;

    localparam int HP = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        sclk, cs_n, sdi;
    logic        sdo_oe, cmd_valid;
    logic [3:0]  cmd_code, cmd_addr;
    logic [15:0] cmd_data, rb_data;
    logic [7:0]  bias;

    int checks = 0;
    int errors = 0;
    int nstrobe = 0;
    bit done = 1'b0;
    logic [23:0] model;

    always #4 clk = ~clk;

    serial_cmd_port dut (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sdo_oe    (sdo_oe),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .rb_data   (rb_data)
    );

    // register-logic stand-in: value depends on the selected code/address
    assign rb_data = {cmd_addr, cmd_code, bias};

    always @(posedge clk) if (!rst && cmd_valid) nstrobe++;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shifts n bits (bits[n-1] first) and compares the serial output with the model
    task automatic run_frame(input logic [31:0] bits, input int n, input string req);
        logic [31:0] got = '0;
        logic [31:0] exp = '0;
        cs_n = 1'b0;
        wait_clk(HP);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            wait_clk(HP);
            got = {got[30:0], ~sdo_oe};
            exp = {exp[30:0], model[23]};
            model = {model[22:0], bits[i]};
            sclk = 1'b1;
            wait_clk(HP);
            sclk = 1'b0;
        end
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(12);
        check(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] frame;
        logic [15:0] data;
        logic [23:0] held;
        int          n0;
        bit          prev_rb;
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; bias = 8'h11;
        model = '0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);

        // R8 reset state
        check(cmd_valid == 1'b0 && {cmd_code, cmd_addr, cmd_data} == 24'h0 && sdo_oe == 1'b0,
              "R8 reset", {7'b0, cmd_valid, cmd_code, cmd_addr, cmd_data}, 32'h0);

        prev_rb = 1'b0;
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 2; a++) begin
                data  = 16'(c * 16'h1357) ^ (a != 0 ? 16'hA5C3 : 16'h0000) ^ 16'h0281;
                frame = {4'(c), 4'(a), data};
                n0 = nstrobe;
                if (c == 0 && a == 0)
                    run_frame({8'h0, frame}, 24, "R8 R4 first frame zeros");
                else if (prev_rb)
                    run_frame({8'h0, frame}, 24, "R5 R10 readback out");
                else
                    run_frame({8'h0, frame}, 24, "R4 R6 daisy pass");
                check(nstrobe == n0 + 1, "R2 one strobe", 32'(nstrobe - n0), 32'd1);
                check({cmd_code, cmd_addr, cmd_data} == frame, "R1 decode",
                      {8'h0, cmd_code, cmd_addr, cmd_data}, {8'h0, frame});
                prev_rb = (c == 9 || c == 10);
                if (prev_rb) begin
                    model[15:0] = {4'(a), 4'(c), bias};
                    bias = bias + 8'h2F;  // R10: later change must not matter
                end
                check(sdo_oe == 1'b0, "R7 idle release", {31'b0, sdo_oe}, 32'h0);
            end
        end

        // R3 / R9 wrong lengths
        held = {cmd_code, cmd_addr, cmd_data};
        n0 = nstrobe;
        run_frame(32'h0012_3456 >> 1, 23, "R4 short frame out");
        check(nstrobe == n0, "R3 23 bits", 32'(nstrobe - n0), 32'd0);
        run_frame(32'h0155_AA3C, 25, "R4 long frame out");
        check(nstrobe == n0, "R3 25 bits", 32'(nstrobe - n0), 32'd0);
        run_frame(32'h0, 0, "R4 empty frame");
        check(nstrobe == n0, "R3 0 bits", 32'(nstrobe - n0), 32'd0);
        check({cmd_code, cmd_addr, cmd_data} == held, "R9 hold",
              {8'h0, cmd_code, cmd_addr, cmd_data}, {8'h0, held});

        // R6 non-readback after partial frames, then R7 with a zero MSB
        frame = 24'hB1_0F0F;
        run_frame({8'h0, frame}, 24, "R4 after partial");
        check(nstrobe == n0 + 1, "R2 strobe", 32'(nstrobe - n0), 32'd1);
        frame = 24'h0_0_0000;
        run_frame({8'h0, frame}, 24, "R6 no substitution");
        cs_n = 1'b0;
        wait_clk(HP);
        check(sdo_oe == 1'b1, "R7 pull low on zero", {31'b0, sdo_oe}, 32'h1);
        cs_n = 1'b1;
        wait_clk(HP);
        check(sdo_oe == 1'b0, "R7 release", {31'b0, sdo_oe}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule